// File: doc/BRIEF.md
# Counter Array Timebase

This block is the shared timebase of a bank of compare/capture units. A 16-bit counter advances on ticks from one of three sources: an internal prescaled clock, a one-cycle pulse from a neighbouring timer, or an external count pin. The pin is synchronised and edge-detected, and its count rate is limited to one count per four clocks. A run bit starts and stops the counter. An idle-gating bit lets a system idle signal freeze it. When the counter rolls over, it sets a sticky overflow flag. That flag raises an interrupt only when its enable bit is set.

Five units watch the counter. A unit in compare mode sets its flag on every clock in which the counter equals its 16-bit compare value. A unit in capture mode latches the counter on a synchronised rising edge of its capture pin and sets its flag. Each unit flag drives its own interrupt line. Hardware only ever sets a flag. Software clears a flag by writing 0 to it over the register bus, and software may also write a 1 to set it.

Software reaches four byte registers on a simple write-strobe bus with a combinational read port. Address 0 is the mode register: bit 7 idle gate, bit 6 watchdog enable (stored only), bits 2:1 source select, bit 0 overflow interrupt enable. Address 1 is the control register: bit 7 overflow flag, bit 6 run, bits 4:0 unit flags. Addresses 2 and 3 are the counter low and high bytes.

The counter is sequenced by a small state machine with three states:
- HALT: the run bit is 0.
- COUNT: the counter advances on ticks.
- IDLE_HOLD: the counter is running but frozen by idle.

Its transitions are:
- START: HALT to COUNT or IDLE_HOLD when run is set.
- STOP: any state to HALT when run is cleared.
- SLEEP: COUNT to IDLE_HOLD when idle is asserted with the gate bit set.
- WAKE: IDLE_HOLD to COUNT when that condition drops.

The state register lags the run bit by one clock.

Top module: `cnt_array_timebase`

## Requirements
- R1: After reset all four registers read 0x00, the counter is 0 and every interrupt output is low.
- R2: With mode bits 2:1 = 0X, the counter advances exactly once every PRESCALE (default 4) clocks while running.
- R3: With mode bits 2:1 = 10, the counter advances once for each clock in which the timer pulse input is high.
- R4: With mode bits 2:1 = 11, the counter advances on each rising edge of the external input after a two-flop synchroniser, but never twice within four clocks; an edge inside that window is dropped.
- R5: The counter advances only while control bit 6 (run) is 1; writes to addresses 2 and 3 load the low and high counter bytes.
- R6: Control bit 7 is set by hardware when the counter rolls from 0xFFFF to 0x0000, stays set until software writes 0 to it, and may be set by software writing 1.
- R7: The overflow interrupt is high exactly when control bit 7 and mode bit 0 are both 1.
- R8: With mode bit 7 = 1 the counter holds while the idle input is high; with mode bit 7 = 0 it keeps counting in idle.
- R9: A compare-mode unit sets its control flag (bit n for unit n) when the counter equals its compare value; the flag stays set until software writes 0, and drives its own interrupt line.
- R10: A capture-mode unit latches the counter value on a synchronised rising edge of its capture input and sets its flag.
- R11: Mode bits 7, 6, 2, 1, 0 read back as written, while mode bits 5:3 and control bit 5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| tmr_ovf_in | input | 1 | Neighbouring timer overflow pulse |
| ext_cnt_in | input | 1 | External count input (asynchronous) |
| idle_in | input | 1 | System idle indication |
| mod_cap_mode | input | N_MOD | Per unit: 1 capture, 0 compare |
| mod_cmp_flat | input | N_MOD*CNT_W | Packed compare values, unit 0 lowest |
| mod_cap_in | input | N_MOD | Capture pins (asynchronous) |
| mod_cap_flat | output | N_MOD*CNT_W | Packed captured values |
| cnt_value | output | CNT_W | Current counter value |
| irq_ovf | output | 1 | Overflow interrupt |
| irq_mod | output | N_MOD | Per-unit interrupts |

## Verification
The bench pushes the counter through 0xFFFF into 0x0000 and checks that the overflow flag is raised there and survives until it is cleared by a write. A design that sets the flag one count late, or lets it decay, fails there. The external input is toggled every other clock to show that edges inside the four-clock window are dropped, while edges exactly four clocks apart all count. A design without the spacing guard would over-count, and one with an off-by-one guard would under-count. Idle gating is tried with both gate settings, and the prescaled source is measured over an exact 40-clock window. Compare flags are checked just before and at the matching count, and captures are checked while the counter is stopped, which exposes a capture of a stale or shifted value.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
    typedef enum logic [1:0] {
        CS_HALT      = 2'd0,
        CS_COUNT     = 2'd1,
        CS_IDLE_HOLD = 2'd2
    } cnt_state_e;

    localparam logic [1:0] ADDR_MODE   = 2'd0;
    localparam logic [1:0] ADDR_CTRL   = 2'd1;
    localparam logic [1:0] ADDR_CNT_LO = 2'd2;
    localparam logic [1:0] ADDR_CNT_HI = 2'd3;

    localparam int MODE_IDLE_BIT = 7;
    localparam int MODE_OVIE_BIT = 0;
    localparam int CTRL_OVF_BIT  = 7;
    localparam int CTRL_RUN_BIT  = 6;

    localparam logic [7:0] MODE_WR_MASK = 8'hC7;
endpackage

// File: rtl/ctb_tick_gen.sv
module ctb_tick_gen #(
    parameter int PRESCALE = 4,
    parameter int EXT_GAP  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       tmr_pulse,
    input  logic       ext_in,
    output logic       tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam int GW = (EXT_GAP > 1) ? $clog2(EXT_GAP) : 1;
    localparam int SW = $clog2(EXT_GAP + 1);

    logic [PW-1:0] pre_q;
    logic          pre_tick;
    logic          ext_s1, ext_s2, ext_s3;
    logic [GW-1:0] guard_q;
    logic          ext_tick;

    assign pre_tick = (pre_q == PW'(PRESCALE - 1));
    assign ext_tick = ext_s2 && !ext_s3 && (guard_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q   <= '0;
            ext_s1  <= 1'b0;
            ext_s2  <= 1'b0;
            ext_s3  <= 1'b0;
            guard_q <= '0;
        end else begin
            pre_q  <= pre_tick ? '0 : pre_q + 1'b1;
            ext_s1 <= ext_in;
            ext_s2 <= ext_s1;
            ext_s3 <= ext_s2;
            if (ext_tick)
                guard_q <= GW'(EXT_GAP - 1);
            else if (guard_q != '0)
                guard_q <= guard_q - 1'b1;
        end
    end

    always_comb begin
        unique case (src_sel)
            2'b10:   tick = tmr_pulse;
            2'b11:   tick = ext_tick;
            default: tick = pre_tick;
        endcase
    end

    // Cycle distance since the last external tick, saturating at EXT_GAP.
    logic [SW-1:0] since_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since_q <= SW'(EXT_GAP);
        else if (ext_tick)
            since_q <= SW'(1);
        else if (since_q < SW'(EXT_GAP))
            since_q <= since_q + 1'b1;
    end

    p_ext_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_tick |-> (since_q >= SW'(EXT_GAP)));
endmodule

// File: rtl/ctb_counter.sv
module ctb_counter
    import ctb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             idle,
    input  logic             idle_stop,
    input  logic             tick,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic [7:0]       ld_data,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam int HI_W = CNT_W - 8;

    cnt_state_e st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic inc, frozen;

    assign frozen = idle && idle_stop;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CS_HALT;
        else        st_q <= st_d;
    end

    // Transitions: START, STOP, SLEEP, WAKE
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CS_HALT:      if (run) st_d = frozen ? CS_IDLE_HOLD : CS_COUNT;
            CS_COUNT:     if (!run) st_d = CS_HALT;
                          else if (frozen) st_d = CS_IDLE_HOLD;
            CS_IDLE_HOLD: if (!run) st_d = CS_HALT;
                          else if (!frozen) st_d = CS_COUNT;
            default:      st_d = CS_HALT;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        inc  = (st_q == CS_COUNT) && tick;
        wrap = inc && (&cnt_q) && !ld_lo && !ld_hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (ld_lo)
            cnt_q[7:0] <= ld_data;
        else if (ld_hi)
            cnt_q[CNT_W-1:8] <= ld_data[HI_W-1:0];
        else if (inc)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

    p_halt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CS_HALT && !ld_lo && !ld_hi) |=> $stable(cnt_q));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CS_IDLE_HOLD && !ld_lo && !ld_hi) |=> $stable(cnt_q));

    p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));
endmodule

// File: rtl/ctb_unit.sv
module ctb_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cap_mode,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             cap_in,
    output logic             hit,
    output logic [CNT_W-1:0] cap_val
);
    logic s1, s2, s3, rise;
    logic [CNT_W-1:0] cap_q;

    assign rise = s2 && !s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1    <= 1'b0;
            s2    <= 1'b0;
            s3    <= 1'b0;
            cap_q <= '0;
        end else begin
            s1 <= cap_in;
            s2 <= s1;
            s3 <= s2;
            if (cap_mode && rise)
                cap_q <= cnt;
        end
    end

    assign hit     = cap_mode ? rise : (cnt == cmp_val);
    assign cap_val = cap_q;

    p_cap_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && rise) |=> (cap_q == $past(cnt)));
endmodule

// File: rtl/cnt_array_timebase.sv
module cnt_array_timebase
    import ctb_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int N_MOD    = 5,
    parameter int PRESCALE = 4,
    parameter int EXT_GAP  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             bus_addr,
    input  logic                   bus_wr,
    input  logic [7:0]             bus_wdata,
    output logic [7:0]             bus_rdata,
    input  logic                   tmr_ovf_in,
    input  logic                   ext_cnt_in,
    input  logic                   idle_in,
    input  logic [N_MOD-1:0]       mod_cap_mode,
    input  logic [N_MOD*CNT_W-1:0] mod_cmp_flat,
    input  logic [N_MOD-1:0]       mod_cap_in,
    output logic [N_MOD*CNT_W-1:0] mod_cap_flat,
    output logic [CNT_W-1:0]       cnt_value,
    output logic                   irq_ovf,
    output logic [N_MOD-1:0]       irq_mod
);
    logic [7:0]       mode_q;
    logic             run_q, ovf_q;
    logic [N_MOD-1:0] mflag_q, hit;
    logic             tick, wrap, ctrl_wr;
    logic [CNT_W-1:0] cnt;

    assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);

    ctb_tick_gen #(.PRESCALE(PRESCALE), .EXT_GAP(EXT_GAP)) u_tick (
        .clk(clk), .rst_n(rst_n), .src_sel(mode_q[2:1]),
        .tmr_pulse(tmr_ovf_in), .ext_in(ext_cnt_in), .tick(tick));

    ctb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run_q), .idle(idle_in),
        .idle_stop(mode_q[MODE_IDLE_BIT]), .tick(tick),
        .ld_lo(bus_wr && bus_addr == ADDR_CNT_LO),
        .ld_hi(bus_wr && bus_addr == ADDR_CNT_HI),
        .ld_data(bus_wdata), .cnt(cnt), .wrap(wrap));

    for (genvar g = 0; g < N_MOD; g++) begin : g_unit
        ctb_unit #(.CNT_W(CNT_W)) u_unit (
            .clk(clk), .rst_n(rst_n), .cnt(cnt),
            .cap_mode(mod_cap_mode[g]),
            .cmp_val(mod_cmp_flat[g*CNT_W +: CNT_W]),
            .cap_in(mod_cap_in[g]), .hit(hit[g]),
            .cap_val(mod_cap_flat[g*CNT_W +: CNT_W]));

        p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (mflag_q[g] && !ctrl_wr) |=> mflag_q[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            run_q   <= 1'b0;
            ovf_q   <= 1'b0;
            mflag_q <= '0;
        end else begin
            if (bus_wr && bus_addr == ADDR_MODE)
                mode_q <= bus_wdata & MODE_WR_MASK;
            if (ctrl_wr) begin
                run_q   <= bus_wdata[CTRL_RUN_BIT];
                ovf_q   <= bus_wdata[CTRL_OVF_BIT] | wrap;
                mflag_q <= bus_wdata[N_MOD-1:0] | hit;
            end else begin
                ovf_q   <= ovf_q | wrap;
                mflag_q <= mflag_q | hit;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_MODE: bus_rdata = mode_q;
            ADDR_CTRL: begin
                bus_rdata[N_MOD-1:0]    = mflag_q;
                bus_rdata[CTRL_RUN_BIT] = run_q;
                bus_rdata[CTRL_OVF_BIT] = ovf_q;
            end
            ADDR_CNT_LO: bus_rdata = cnt[7:0];
            default:     bus_rdata = 8'(cnt[CNT_W-1:8]);
        endcase
    end

    assign cnt_value = cnt;
    assign irq_ovf   = ovf_q && mode_q[MODE_OVIE_BIT];
    assign irq_mod   = mflag_q;

    p_ovf_hw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_q);

    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(ctrl_wr && !bus_wdata[CTRL_OVF_BIT])) |=> ovf_q);
endmodule

// File: tb/cnt_array_timebase_tb.sv
module cnt_array_timebase_tb_top;
    localparam int CW = 16;
    localparam int NM = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          tmr_ovf_in = 1'b0;
    logic          ext_cnt_in = 1'b0;
    logic          idle_in = 1'b0;
    logic [NM-1:0] mod_cap_mode = 5'b00010;
    logic [NM*CW-1:0] mod_cmp_flat = {16'h7000, 16'h4000, 16'h1234, 16'h0000, 16'h0005};
    logic [NM-1:0] mod_cap_in = '0;
    logic [NM*CW-1:0] mod_cap_flat;
    logic [CW-1:0] cnt_value;
    logic          irq_ovf;
    logic [NM-1:0] irq_mod;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    cnt_array_timebase dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_ovf_in(tmr_ovf_in),
        .ext_cnt_in(ext_cnt_in), .idle_in(idle_in), .mod_cap_mode(mod_cap_mode),
        .mod_cmp_flat(mod_cmp_flat), .mod_cap_in(mod_cap_in),
        .mod_cap_flat(mod_cap_flat), .cnt_value(cnt_value),
        .irq_ovf(irq_ovf), .irq_mod(irq_mod));

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic load(input logic [15:0] v);
        wr(2'd2, v[7:0]);
        wr(2'd3, v[15:8]);
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            tmr_ovf_in = 1'b1;
            @(negedge clk);
            tmr_ovf_in = 1'b0;
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check(d == 8'h00, "R1 register reset", d, 0);
        end
        check(irq_ovf == 1'b0 && irq_mod == '0, "R1 irq reset", {irq_ovf, irq_mod}, 0);
    endtask

    task automatic t_readback;
        logic [7:0] d;
        wr(2'd0, 8'hFF);
        rd(2'd0, d);
        check(d == 8'hC7, "R11 mode readback", d, 8'hC7);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h20);
        rd(2'd1, d);
        check(d == 8'h00, "R11 control reserved bit", d, 0);
    endtask

    task automatic t_timer_src;
        wr(2'd0, 8'h04);
        load(16'h0000);
        wr(2'd1, 8'h40);
        cycles(2);
        pulse(3);
        check(cnt_value == 16'd3, "R3 timer pulses counted", cnt_value, 3);
        wr(2'd1, 8'h00);
        cycles(2);
        pulse(2);
        check(cnt_value == 16'd3, "R5 run off holds", cnt_value, 3);
        load(16'h2345);
        check(cnt_value == 16'h2345, "R5 counter load", cnt_value, 16'h2345);
    endtask

    task automatic t_prescale;
        logic [15:0] c0;
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h40);
        cycles(3);
        c0 = cnt_value;
        cycles(40);
        check(cnt_value - c0 == 16'd10, "R2 prescaled rate", cnt_value - c0, 10);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_ext_src;
        logic [15:0] c0;
        wr(2'd0, 8'h06);
        wr(2'd1, 8'h40);
        cycles(6);
        c0 = cnt_value;
        for (int i = 0; i < 4; i++) begin
            ext_cnt_in = 1'b1; cycles(2);
            ext_cnt_in = 1'b0; cycles(2);
        end
        cycles(6);
        check(cnt_value - c0 == 16'd4, "R4 spaced edges all count", cnt_value - c0, 4);
        c0 = cnt_value;
        for (int i = 0; i < 4; i++) begin
            ext_cnt_in = 1'b1; cycles(1);
            ext_cnt_in = 1'b0; cycles(1);
        end
        cycles(8);
        check(cnt_value - c0 == 16'd2, "R4 close edges dropped", cnt_value - c0, 2);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_overflow;
        logic [7:0] d;
        wr(2'd0, 8'h04);
        load(16'hFFFE);
        wr(2'd1, 8'h40);
        cycles(2);
        pulse(1);
        rd(2'd1, d);
        check(d[7] == 1'b0, "R6 no flag before wrap", d, 8'h40);
        pulse(1);
        rd(2'd1, d);
        check(d[7] == 1'b1 && cnt_value == 16'h0000, "R6 flag on wrap", {d, cnt_value}, 24'h800000);
        check(irq_ovf == 1'b0, "R7 irq masked", irq_ovf, 0);
        wr(2'd0, 8'h05);
        check(irq_ovf == 1'b1, "R7 irq enabled", irq_ovf, 1);
        cycles(3);
        rd(2'd1, d);
        check(d[7] == 1'b1, "R6 flag sticky", d, 8'hC0);
        wr(2'd1, 8'h40);
        rd(2'd1, d);
        check(d[7] == 1'b0 && irq_ovf == 1'b0, "R6 software clear", {d, irq_ovf}, 0);
        wr(2'd1, 8'hC0);
        rd(2'd1, d);
        check(d[7] == 1'b1, "R6 software set", d, 8'hC0);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h04);
    endtask

    task automatic t_idle;
        wr(2'd0, 8'h84);
        load(16'h0000);
        idle_in = 1'b1;
        wr(2'd1, 8'h40);
        cycles(3);
        pulse(3);
        check(cnt_value == 16'd0, "R8 idle gate holds", cnt_value, 0);
        wr(2'd0, 8'h04);
        cycles(3);
        pulse(3);
        check(cnt_value == 16'd3, "R8 idle ungated counts", cnt_value, 3);
        idle_in = 1'b0;
        wr(2'd1, 8'h00);
    endtask

    task automatic t_compare;
        logic [7:0] d;
        load(16'h0000);
        wr(2'd1, 8'h00);
        wr(2'd1, 8'h40);
        cycles(2);
        pulse(4);
        cycles(1);
        check(irq_mod == '0, "R9 no match at 4", irq_mod, 0);
        pulse(1);
        cycles(1);
        check(irq_mod == 5'b00001, "R9 match at 5", irq_mod, 1);
        wr(2'd1, 8'h01);
        load(16'h0010);
        cycles(2);
        rd(2'd1, d);
        check(d == 8'h01, "R9 flag sticky", d, 1);
        wr(2'd1, 8'h00);
        check(irq_mod == '0, "R9 flag cleared", irq_mod, 0);
    endtask

    task automatic t_capture;
        logic [7:0] d;
        load(16'h0ABC);
        mod_cap_in[1] = 1'b1;
        cycles(5);
        check(mod_cap_flat[CW +: CW] == 16'h0ABC, "R10 captured value",
              mod_cap_flat[CW +: CW], 16'h0ABC);
        rd(2'd1, d);
        check(d == 8'h02 && irq_mod == 5'b00010, "R10 capture flag", {d, 3'b0, irq_mod}, 16'h0202);
        mod_cap_in[1] = 1'b0;
    endtask

    bit done = 1'b0;

    initial begin
        cycles(5);
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_readback();
        t_timer_src();
        t_prescale();
        t_ext_src();
        t_overflow();
        t_idle();
        t_compare();
        t_capture();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule